// File: doc/BRIEF.md
# Expansion card address decoder

This block sits between a host memory bus and the parts of a floppy-disk peripheral card: a banked boot ROM, a two-page buffer RAM, a floppy controller register file and a real-time clock. Each cycle it takes the host address, the transfer direction and a few card controls (card enable, clock overlay, ROM bank and RAM page). One clock later it presents registered chip selects, local addresses and register indices. It also presents a read-drive enable that tells the bus when the card owns the data lines.

The card answers inside an 8 KB window of the host space. The standard host uses a 19-bit window test and a strapped alternative host uses a 21-bit one. The lowest 7 KB of the window is ROM. The top 1 KB is buffer RAM, except where a peripheral claims a slot. The controller's registers are placed one way for reads and another way for writes, so each byte slot in its 16-byte area serves one direction. When the clock overlay is on, the controller disappears and the clock takes the even bytes of the top 32 bytes.

The registered target is held as an enumerated state. There are five states: IDLE (no card part selected), ROM, RAM, FDC (controller) and RTC (clock). On every clock edge the state moves to the target decoded from that cycle's inputs. Every transition between any two states is allowed, and reset forces IDLE.

Top module: `card_addr_decoder`

## Requirements
- R1: In the standard host mode (`alt_host`=0) the card window is hit when (host_addr AND 0x07E000) equals 0x074000. The offset inside the window is host_addr[12:0].
- R2: With `alt_host`=1 the window is hit when (host_addr AND 0x1FE000) equals 0x174000. Addresses outside the window select nothing.
- R3: While `card_en` is 0, no select, pre-select or read-drive output is raised.
- R4: A read at offsets 0x0000–0x1BFF raises `rom_sel` with `rom_addr` = {rom_bank[1:0], offset[12:0]}. A write in that range raises no select.
- R5: An access whose offset bits [12:10] are all 1 raises `ram_sel` with `ram_addr` = {ram_page, offset[9:0]}, in either direction, unless the controller or the clock claims it.
- R6: With `clk_ovl`=0, an even read at 0x1FF0–0x1FF7 or an even write at 0x1FF8–0x1FFF raises `fdc_sel` with `fdc_reg` = offset[2:1]. A read at 0x1FF8–0x1FFF and a write at 0x1FF0–0x1FF7 go to RAM.
- R7: An odd offset inside the range R6 assigns to the current direction raises `fdc_presel` but not `fdc_sel`, and the access is served by RAM. `fdc_presel` is also high whenever `fdc_sel` is.
- R8: With `clk_ovl`=1, `fdc_sel` and `fdc_presel` stay low. An even offset in 0x1FE0–0x1FFE raises `rtc_sel` with `rtc_reg` = offset[4:1], in either direction, and an odd offset there goes to RAM.
- R9: At most one of `rom_sel`, `ram_sel`, `fdc_sel`, `rtc_sel` is high in any cycle.
- R10: `rd_drive` is high exactly when the decoded access is a read that raised one of the four selects.
- R11: All outputs are registered. They reflect the inputs sampled at the previous rising edge, and they are all 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | 21 | Host byte address |
| host_rd | input | 1 | 1 = read, 0 = write |
| alt_host | input | 1 | Strap: use the wider alternative window test |
| card_en | input | 1 | Card enable control bit |
| clk_ovl | input | 1 | Clock overlay enable |
| rom_bank | input | 2 | ROM bank number |
| ram_page | input | 1 | Buffer RAM page |
| rom_sel | output | 1 | ROM chip select |
| rom_addr | output | 15 | ROM local address |
| ram_sel | output | 1 | RAM chip select |
| ram_addr | output | 11 | RAM local address |
| fdc_presel | output | 1 | Controller pre-select (even and odd), for wait-state logic |
| fdc_sel | output | 1 | Controller register access (even only) |
| fdc_reg | output | 2 | Controller register index |
| rtc_sel | output | 1 | Clock chip select |
| rtc_reg | output | 4 | Clock register index |
| rd_drive | output | 1 | Card drives read data onto the bus |

## Verification
A wrong registered target state shows at the ports in the very next cycle. Two selects high together, or a select with the wrong index or page, appears one clock after the offending address. The sharpest cases are the slots whose owner depends on direction or overlay: 0x1FF0 versus 0x1FF8, the odd bytes beside controller registers, and 0x1FDF versus 0x1FE0. The bench therefore sweeps the whole top 1 KB in both directions and both overlay settings, and it compares every output one cycle after each address is driven.

// File: rtl/card_dec_pkg.sv
package card_dec_pkg;
    typedef enum logic [2:0] {
        TGT_IDLE = 3'd0,
        TGT_ROM  = 3'd1,
        TGT_RAM  = 3'd2,
        TGT_FDC  = 3'd3,
        TGT_RTC  = 3'd4
    } tgt_e;

    localparam int FDC_IDX_W = 2;
    localparam int RTC_IDX_W = 4;
endpackage

// File: rtl/card_win_match.sv
module card_win_match #(
    parameter int          ADDR_W   = 21,
    parameter logic [31:0] MASK_STD = 32'h0007_E000,
    parameter logic [31:0] BASE_STD = 32'h0007_4000,
    parameter logic [31:0] MASK_ALT = 32'h001F_E000,
    parameter logic [31:0] BASE_ALT = 32'h0017_4000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              alt_mode,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] M_S = MASK_STD[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] B_S = BASE_STD[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] M_A = MASK_ALT[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] B_A = BASE_ALT[ADDR_W-1:0];

    logic hit_std, hit_alt;

    always_comb begin
        hit_std = ((addr & M_S) == B_S);
        hit_alt = ((addr & M_A) == B_A);
        hit     = alt_mode ? hit_alt : hit_std;
    end
endmodule

// File: rtl/card_region_dec.sv
module card_region_dec
    import card_dec_pkg::*;
#(
    parameter int OFF_W      = 13,
    parameter int RAM_OFF_W  = 10,
    parameter int ROM_PAGE_W = 2,
    parameter int RAM_PAGE_W = 1
) (
    input  logic [OFF_W-1:0]            off,
    input  logic                        rd,
    input  logic                        sel,
    input  logic                        ovl,
    input  logic [ROM_PAGE_W-1:0]       rom_page,
    input  logic [RAM_PAGE_W-1:0]       ram_page,
    output tgt_e                        tgt,
    output logic                        presel,
    output logic [ROM_PAGE_W+OFF_W-1:0] rom_a,
    output logic [RAM_PAGE_W+RAM_OFF_W-1:0] ram_a,
    output logic [FDC_IDX_W-1:0]        fdc_idx,
    output logic [RTC_IDX_W-1:0]        rtc_idx
);
    // Top 16 bytes belong to the controller; the top 32 to the clock.
    localparam int FDC_LO = 4;
    localparam int RTC_LO = 5;

    logic last_k, fdc_zone, rtc_zone;

    always_comb begin
        last_k   = &off[OFF_W-1:RAM_OFF_W];
        // bit 3 clear selects the read half, set selects the write half
        fdc_zone = (&off[OFF_W-1:FDC_LO]) && (off[3] != rd);
        rtc_zone = (&off[OFF_W-1:RTC_LO]) && !off[0];

        presel   = sel && !ovl && fdc_zone;
        rom_a    = {rom_page, off};
        ram_a    = {ram_page, off[RAM_OFF_W-1:0]};
        fdc_idx  = off[2:1];
        rtc_idx  = off[4:1];

        if (!sel)                          tgt = TGT_IDLE;
        else if (!last_k)                  tgt = rd ? TGT_ROM : TGT_IDLE;
        else if (presel && !off[0])        tgt = TGT_FDC;
        else if (ovl && rtc_zone)          tgt = TGT_RTC;
        else                               tgt = TGT_RAM;
    end
endmodule

// File: rtl/card_addr_decoder.sv
module card_addr_decoder
    import card_dec_pkg::*;
#(
    parameter int ADDR_W     = 21,
    parameter int OFF_W      = 13,
    parameter int RAM_OFF_W  = 10,
    parameter int ROM_PAGE_W = 2,
    parameter int RAM_PAGE_W = 1,
    localparam int ROM_A_W   = ROM_PAGE_W + OFF_W,
    localparam int RAM_A_W   = RAM_PAGE_W + RAM_OFF_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     host_addr,
    input  logic                  host_rd,
    input  logic                  alt_host,
    input  logic                  card_en,
    input  logic                  clk_ovl,
    input  logic [ROM_PAGE_W-1:0] rom_bank,
    input  logic [RAM_PAGE_W-1:0] ram_page,
    output logic                  rom_sel,
    output logic [ROM_A_W-1:0]    rom_addr,
    output logic                  ram_sel,
    output logic [RAM_A_W-1:0]    ram_addr,
    output logic                  fdc_presel,
    output logic                  fdc_sel,
    output logic [1:0]            fdc_reg,
    output logic                  rtc_sel,
    output logic [3:0]            rtc_reg
    ,output logic                 rd_drive
);
    logic                 win_hit, card_hit;
    tgt_e                 tgt_d, tgt_q;
    logic                 pre_d, pre_q, rd_q;
    logic [ROM_A_W-1:0]   rom_a_d, rom_a_q;
    logic [RAM_A_W-1:0]   ram_a_d, ram_a_q;
    logic [1:0]           fdc_d, fdc_q;
    logic [3:0]           rtc_d, rtc_q;

    card_win_match #(.ADDR_W(ADDR_W)) u_win (
        .addr     (host_addr),
        .alt_mode (alt_host),
        .hit      (win_hit)
    );

    assign card_hit = win_hit && card_en;

    card_region_dec #(
        .OFF_W(OFF_W), .RAM_OFF_W(RAM_OFF_W),
        .ROM_PAGE_W(ROM_PAGE_W), .RAM_PAGE_W(RAM_PAGE_W)
    ) u_region (
        .off      (host_addr[OFF_W-1:0]),
        .rd       (host_rd),
        .sel      (card_hit),
        .ovl      (clk_ovl),
        .rom_page (rom_bank),
        .ram_page (ram_page),
        .tgt      (tgt_d),
        .presel   (pre_d),
        .rom_a    (rom_a_d),
        .ram_a    (ram_a_d),
        .fdc_idx  (fdc_d),
        .rtc_idx  (rtc_d)
    );

    // State register: the decoded target of the access just sampled.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q   <= TGT_IDLE;
            pre_q   <= 1'b0;
            rd_q    <= 1'b0;
            rom_a_q <= '0;
            ram_a_q <= '0;
            fdc_q   <= '0;
            rtc_q   <= '0;
        end else begin
            tgt_q   <= tgt_d;
            pre_q   <= pre_d;
            rd_q    <= host_rd;
            rom_a_q <= rom_a_d;
            ram_a_q <= ram_a_d;
            fdc_q   <= fdc_d;
            rtc_q   <= rtc_d;
        end
    end

    // Output process: one-hot selects driven from the state.
    always_comb begin
        rom_sel    = 1'b0;
        rom_addr   = '0;
        ram_sel    = 1'b0;
        ram_addr   = '0;
        fdc_sel    = 1'b0;
        fdc_reg    = '0;
        rtc_sel    = 1'b0;
        rtc_reg    = '0;
        fdc_presel = pre_q;
        rd_drive   = rd_q && (tgt_q != TGT_IDLE);
        unique case (tgt_q)
            TGT_IDLE: ;
            TGT_ROM: begin
                rom_sel  = 1'b1;
                rom_addr = rom_a_q;
            end
            TGT_RAM: begin
                ram_sel  = 1'b1;
                ram_addr = ram_a_q;
            end
            TGT_FDC: begin
                fdc_sel  = 1'b1;
                fdc_reg  = fdc_q;
            end
            TGT_RTC: begin
                rtc_sel  = 1'b1;
                rtc_reg  = rtc_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/card_addr_decoder_chk.sv
module card_addr_decoder_chk (
    input logic clk,
    input logic rst_n,
    input logic host_rd,
    input logic card_en,
    input logic clk_ovl,
    input logic rom_sel,
    input logic ram_sel,
    input logic fdc_presel,
    input logic fdc_sel,
    input logic rtc_sel,
    input logic rd_drive
);
    a_r9_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_sel, ram_sel, fdc_sel, rtc_sel}));

    a_r3_card_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(card_en) |-> !(rom_sel || ram_sel || fdc_sel || rtc_sel || fdc_presel || rd_drive));

    a_r4_no_rom_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(host_rd) |-> !rom_sel);

    a_r7_presel_covers: assert property (@(posedge clk) disable iff (!rst_n)
        fdc_sel |-> fdc_presel);

    a_r8_overlay_no_fdc: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clk_ovl) |-> !(fdc_sel || fdc_presel));

    a_r10_drive_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_drive |-> ($past(host_rd) && (rom_sel || ram_sel || fdc_sel || rtc_sel)));

    always @(posedge clk) begin
        if (!rst_n) begin
            a_r11_reset_idle: assert (!(rom_sel || ram_sel || fdc_sel || rtc_sel || rd_drive) || $isunknown(rom_sel));
        end
    end
endmodule

bind card_addr_decoder card_addr_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_rd    (host_rd),
    .card_en    (card_en),
    .clk_ovl    (clk_ovl),
    .rom_sel    (rom_sel),
    .ram_sel    (ram_sel),
    .fdc_presel (fdc_presel),
    .fdc_sel    (fdc_sel),
    .rtc_sel    (rtc_sel),
    .rd_drive   (rd_drive)
);

// File: tb/card_addr_decoder_tb.sv
module card_addr_decoder_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        rom;
        logic        ram;
        logic        pre;
        logic        fdc;
        logic        rtc;
        logic        drv;
        logic [14:0] rom_a;
        logic [10:0] ram_a;
        logic [1:0]  fdc_i;
        logic [3:0]  rtc_i;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [20:0] host_addr = '0;
    logic        host_rd = 1'b1;
    logic        alt_host = 1'b0;
    logic        card_en = 1'b0;
    logic        clk_ovl = 1'b0;
    logic [1:0]  rom_bank = '0;
    logic [0:0]  ram_page = '0;
    logic        rom_sel, ram_sel, fdc_presel, fdc_sel, rtc_sel, rd_drive;
    logic [14:0] rom_addr;
    logic [10:0] ram_addr;
    logic [1:0]  fdc_reg;
    logic [3:0]  rtc_reg;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    exp_t  exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    card_addr_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
        .alt_host(alt_host), .card_en(card_en), .clk_ovl(clk_ovl),
        .rom_bank(rom_bank), .ram_page(ram_page),
        .rom_sel(rom_sel), .rom_addr(rom_addr), .ram_sel(ram_sel), .ram_addr(ram_addr),
        .fdc_presel(fdc_presel), .fdc_sel(fdc_sel), .fdc_reg(fdc_reg),
        .rtc_sel(rtc_sel), .rtc_reg(rtc_reg), .rd_drive(rd_drive)
    );

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [20:0] a, input logic rd, input logic alt,
                                   input logic en, input logic ovl,
                                   input logic [1:0] rb, input logic rp);
        exp_t  e;
        logic  hit, sel, lastk;
        logic [12:0] o;
        e   = '0;
        o   = a[12:0];
        hit = alt ? ((a & 21'h1FE000) == 21'h174000) : ((a & 21'h07E000) == 21'h074000);
        sel = hit && en;
        lastk = (o[12:10] == 3'b111);
        e.pre = sel && !ovl && (rd ? ((o & 13'h1FF8) == 13'h1FF0) : ((o & 13'h1FF8) == 13'h1FF8));
        e.fdc = e.pre && !o[0];
        e.rtc = sel && ovl && ((o & 13'h1FE1) == 13'h1FE0);
        e.ram = sel && lastk && !e.fdc && !e.rtc;
        e.rom = sel && !lastk && rd;
        e.drv = rd && (e.rom || e.ram || e.fdc || e.rtc);
        e.rom_a = {rb, o};
        e.ram_a = {rp, o[9:0]};
        e.fdc_i = o[2:1];
        e.rtc_i = o[4:1];
        return e;
    endfunction

    task automatic drive(input logic [20:0] a, input logic rd, input logic alt,
                         input logic en, input logic ovl, input logic [1:0] rb,
                         input logic rp, input string tag);
        @(negedge clk);
        host_addr = a; host_rd = rd; alt_host = alt; card_en = en;
        clk_ovl = ovl; rom_bank = rb; ram_page = rp;
        exp_q.push_back(model(a, rd, alt, en, ovl, rb, rp));
        tag_q.push_back(tag);
    endtask

    // Monitor: results appear one edge after the driver's negedge.
    always @(posedge clk) begin
        #1;
        if (rst_n && exp_q.size() > 0) begin
            exp_t  e;
            string t;
            logic  bad;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            bad = (rom_sel != e.rom) || (ram_sel != e.ram) || (fdc_presel != e.pre) ||
                  (fdc_sel != e.fdc) || (rtc_sel != e.rtc) || (rd_drive != e.drv) ||
                  (e.rom && rom_addr != e.rom_a) || (e.ram && ram_addr != e.ram_a) ||
                  (e.fdc && fdc_reg != e.fdc_i) || (e.rtc && rtc_reg != e.rtc_i);
            checks++;
            if (bad) begin
                failures++;
                $display("FAIL %s: got rom=%b ram=%b pre=%b fdc=%b rtc=%b drv=%b ra=%h wa=%h fi=%0d ci=%0d exp rom=%b ram=%b pre=%b fdc=%b rtc=%b drv=%b ra=%h wa=%h fi=%0d ci=%0d",
                    t, rom_sel, ram_sel, fdc_presel, fdc_sel, rtc_sel, rd_drive,
                    rom_addr, ram_addr, fdc_reg, rtc_reg,
                    e.rom, e.ram, e.pre, e.fdc, e.rtc, e.drv, e.rom_a, e.ram_a, e.fdc_i, e.rtc_i);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (rom_sel || ram_sel || fdc_sel || rtc_sel || fdc_presel || rd_drive) begin
            failures++;
            $display("FAIL R11: got selects active in reset exp all 0");
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1 window edges, standard mode
        drive(21'h074000, 1, 0, 1, 0, 2'd0, 0, "R1");
        drive(21'h073FFF, 1, 0, 1, 0, 2'd0, 0, "R1");
        drive(21'h076000, 1, 0, 1, 0, 2'd0, 0, "R1");
        drive(21'h174000, 1, 0, 1, 0, 2'd1, 0, "R1");
        // R2 alternative host
        drive(21'h174000, 1, 1, 1, 0, 2'd2, 0, "R2");
        drive(21'h074000, 1, 1, 1, 0, 2'd2, 0, "R2");
        drive(21'h175FFF, 0, 1, 1, 0, 2'd0, 1, "R2");
        // R3 card disabled
        drive(21'h075FF0, 1, 0, 0, 0, 2'd0, 0, "R3");
        drive(21'h075C00, 0, 0, 0, 1, 2'd0, 0, "R3");
        // R4 ROM banks and write ignore
        drive(21'h075BFF, 1, 0, 1, 0, 2'd3, 0, "R4");
        drive(21'h074001, 1, 0, 1, 1, 2'd1, 0, "R4");
        drive(21'h074000, 0, 0, 1, 0, 2'd3, 0, "R4");
        drive(21'h075BFF, 0, 0, 1, 0, 2'd3, 0, "R4");
        // R5 RAM start / paging
        drive(21'h075C00, 1, 0, 1, 0, 2'd0, 1, "R5");
        drive(21'h075C00, 0, 0, 1, 0, 2'd0, 0, "R5");
        // R6 direction-dependent placement
        drive(21'h075FF0, 1, 0, 1, 0, 2'd0, 0, "R6");
        drive(21'h075FF6, 1, 0, 1, 0, 2'd0, 0, "R6");
        drive(21'h075FF8, 1, 0, 1, 0, 2'd0, 0, "R6");
        drive(21'h075FF8, 0, 0, 1, 0, 2'd0, 0, "R6");
        drive(21'h075FF0, 0, 0, 1, 0, 2'd0, 1, "R6");
        // R7 odd bytes
        drive(21'h075FF7, 1, 0, 1, 0, 2'd0, 1, "R7");
        drive(21'h075FFF, 0, 0, 1, 0, 2'd0, 0, "R7");
        // R8 clock overlay
        drive(21'h075FDF, 1, 0, 1, 1, 2'd0, 0, "R8");
        drive(21'h075FE0, 1, 0, 1, 1, 2'd0, 0, "R8");
        drive(21'h075FE1, 0, 0, 1, 1, 2'd0, 0, "R8");
        drive(21'h075FF0, 1, 0, 1, 1, 2'd0, 0, "R8");
        drive(21'h075FFE, 0, 0, 1, 1, 2'd0, 0, "R8");

        // R9 and R10: full sweep of the top 1 KB, both overlays, both directions
        for (int ov = 0; ov < 2; ov++) begin
            for (int d = 0; d < 2; d++) begin
                for (int o = 13'h1C00; o < 13'h2000; o++) begin
                    drive(21'h074000 | 21'(o), d[0], 0, 1, ov[0], 2'd0, 1'(o >> 4), "R9/R10 sweep");
                end
            end
        end

        @(negedge clk);
        host_addr = '0; card_en = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule